// File: doc/BRIEF.md
# Camera Pixel Input Unpacker

This block takes an 8-bit parallel camera bus (data, pixel clock, horizontal sync, vertical sync) and turns it into a stream of pixel words in the system clock domain. The pixel clock is treated as a data signal. A two-stage sampler on the system clock finds the capture transition of the pixel clock, with the polarity chosen by configuration. Each byte taken at that transition joins a byte group. For YCbCr 4:2:2 a group is four bytes and makes two pixels. For RGB565 a group is two bytes and makes one pixel. The byte order within a group is one of four codes for each input format.

When a group is complete, the block reorders the bytes into components. It applies the per-component posterize masks and the monochrome setting, then packs the pixel into a 16-bit output word in the selected output format. Each pixel appears as a one-cycle `out_valid` pulse.

Format, byte order, output format, monochrome and the three masks are static inputs, taken into the block when vertical sync becomes active. The three polarity inputs are used directly. The system clock must run at least three times faster than the pixel clock.

Top module: `cam_unpack`

## Requirements
- R1: While reset is asserted, and after reset until a complete byte group has been captured, `out_valid` stays 0.
- R2: With `cfg_pclk_rise`=1 a byte is captured on each rising pixel-clock transition, and with 0 on each falling transition. The opposite transition captures nothing.
- R3: HSYNC is active at level `cfg_hs_high` and VSYNC at level `cfg_vs_high`. Bytes are accepted only while HSYNC is active and VSYNC is inactive; any other byte produces no output.
- R4: The byte position returns to the first byte of a group each time HSYNC or VSYNC becomes active. A partial group left from the previous line is dropped.
- R5: YCbCr input (`cfg_in_rgb`=0) groups bytes in fours. The order codes are 00: Y0,U,Y1,V; 01: Y0,V,Y1,U; 10: U,Y0,V,Y1; 11: V,Y0,U,Y1 (first byte first). After the fourth byte two pixels come out on consecutive cycles: {U,Y0} first and then {V,Y1}, with chroma in bits 15:8.
- R6: RGB565 input (`cfg_in_rgb`=1) groups bytes in pairs and gives exactly one pixel per pair. The order codes are 00: first=R[4:0]G[5:3], second=G[2:0]B[4:0]; 01: first=B[4:0]G[5:3], second=G[2:0]R[4:0]; 10: first=G[2:0]B[4:0], second=R[4:0]G[5:3]; 11: first=G[2:0]R[4:0], second=B[4:0]G[5:3].
- R7: `cfg_out_fmt` has four codes. 00 gives the YCbCr word of R5. 01 gives luma only, as {8'h00,Y}. 10 gives RGB555, as {1'b0,R,G[5:1],B}. 11 gives RGB565, as {R,G,B}. A YCbCr input with code 10 or 11 leaves the block unchanged in the code 00 word. An RGB input with code 00 or 01 leaves as the RGB565 word.
- R8: With `cfg_mono`=1 and YCbCr input, the U and V components are replaced by zero.
- R9: With YCbCr input, the output Y, U and V are ANDed with `cfg_mask_y`, `cfg_mask_u` and `cfg_mask_v`.
- R10: Format, order, output format, monochrome and masks take effect only at the cycle VSYNC becomes active. Changes at any other time do not affect the frame in progress.
- R11: The first pixel of a group is registered on the second system-clock rising edge after the capturing pixel-clock level is applied. The second YCbCr pixel follows one cycle later, and each pixel's `out_valid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cam_pclk | input | 1 | Camera pixel clock, sampled as data |
| cam_hsync | input | 1 | Camera horizontal sync |
| cam_vsync | input | 1 | Camera vertical sync |
| cam_data | input | 8 | Camera data byte |
| cfg_pclk_rise | input | 1 | 1: capture on rising pixel-clock transition, 0: falling |
| cfg_hs_high | input | 1 | Active level of HSYNC |
| cfg_vs_high | input | 1 | Active level of VSYNC |
| cfg_in_rgb | input | 1 | 0: YCbCr 4:2:2 input, 1: RGB565 input |
| cfg_order | input | 2 | Byte order code within a group |
| cfg_out_fmt | input | 2 | Output packing code |
| cfg_mono | input | 1 | Discard chroma |
| cfg_mask_y | input | 8 | Luma posterize mask |
| cfg_mask_u | input | 8 | U posterize mask |
| cfg_mask_v | input | 8 | V posterize mask |
| out_valid | output | 1 | One-cycle pixel strobe |
| out_word | output | 16 | Packed pixel word |

## Verification
Each result has a fixed due cycle. A byte driven with its capturing pixel-clock level in one cycle gives its first pixel two system-clock cycles later, and the second YCbCr pixel one cycle after that. The bench holds each pixel-clock level for two cycles and records every `out_valid` pulse from a monitor at the falling system-clock edge, so every scenario compares a complete pulse list against values it built from the requirements. The latency scenario checks `out_valid` cycle by cycle around one capture to confirm exactly when each pulse appears.

// File: rtl/cam_unpack_pkg.sv
package cam_unpack_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        OUT_YUV    = 2'b00,
        OUT_LUMA   = 2'b01,
        OUT_RGB555 = 2'b10,
        OUT_RGB565 = 2'b11
    } out_fmt_e;

    typedef struct packed {
        logic              in_rgb;
        logic [1:0]        order;
        logic              mono;
        out_fmt_e          out_fmt;
        logic [BYTE_W-1:0] mask_y;
        logic [BYTE_W-1:0] mask_u;
        logic [BYTE_W-1:0] mask_v;
    } frame_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] y0;
        logic [BYTE_W-1:0] u;
        logic [BYTE_W-1:0] y1;
        logic [BYTE_W-1:0] v;
    } yuv_pair_t;

    typedef struct packed {
        logic [4:0] r;
        logic [5:0] g;
        logic [4:0] b;
    } rgb_pix_t;

endpackage

// File: rtl/cam_sampler.sv
module cam_sampler #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk_in,
    input  logic              hs_in,
    input  logic              vs_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              pclk_rise,
    input  logic              hs_high,
    input  logic              vs_high,
    output logic              cap,
    output logic [DATA_W-1:0] cap_data,
    output logic              line_act,
    output logic              frame_act,
    output logic              line_start,
    output logic              frame_start
);

    typedef struct packed {
        logic              pclk_a;
        logic              pclk_b;
        logic              hs_a;
        logic              hs_b;
        logic              vs_a;
        logic              vs_b;
        logic [DATA_W-1:0] data_a;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d        = smp_q;
        smp_d.pclk_a = pclk_in;
        smp_d.pclk_b = smp_q.pclk_a;
        smp_d.hs_a   = hs_in;
        smp_d.hs_b   = smp_q.hs_a;
        smp_d.vs_a   = vs_in;
        smp_d.vs_b   = smp_q.vs_a;
        smp_d.data_a = data_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    logic hs_prev_act, vs_prev_act;

    assign cap         = pclk_rise ? (smp_q.pclk_a & ~smp_q.pclk_b)
                                   : (~smp_q.pclk_a & smp_q.pclk_b);
    assign cap_data    = smp_q.data_a;
    assign line_act    = (smp_q.hs_a == hs_high);
    assign frame_act   = (smp_q.vs_a == vs_high);
    assign hs_prev_act = (smp_q.hs_b == hs_high);
    assign vs_prev_act = (smp_q.vs_b == vs_high);
    assign line_start  = line_act & ~hs_prev_act;
    assign frame_start = frame_act & ~vs_prev_act;

    // A pixel clock at most a third of clk yields isolated strobes
    AST_ONE_STROBE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> !cap); // R2

endmodule

// File: rtl/cam_yuv_order.sv
module cam_yuv_order
    import cam_unpack_pkg::*;
(
    input  logic [1:0]             order,
    input  logic [3:0][BYTE_W-1:0] grp,
    output yuv_pair_t              pair
);

    always_comb begin
        unique case (order)
            2'b00: pair = '{y0: grp[0], u: grp[1], y1: grp[2], v: grp[3]};
            2'b01: pair = '{y0: grp[0], v: grp[1], y1: grp[2], u: grp[3]};
            2'b10: pair = '{u: grp[0], y0: grp[1], v: grp[2], y1: grp[3]};
            default: pair = '{v: grp[0], y0: grp[1], u: grp[2], y1: grp[3]};
        endcase
    end

endmodule

// File: rtl/cam_rgb_order.sv
module cam_rgb_order
    import cam_unpack_pkg::*;
(
    input  logic [1:0]        order,
    input  logic [BYTE_W-1:0] first,
    input  logic [BYTE_W-1:0] second,
    output rgb_pix_t          pix
);

    always_comb begin
        unique case (order)
            2'b00: pix = '{r: first[7:3],  g: {first[2:0], second[7:5]},  b: second[4:0]};
            2'b01: pix = '{b: first[7:3],  g: {first[2:0], second[7:5]},  r: second[4:0]};
            2'b10: pix = '{b: first[4:0],  g: {second[2:0], first[7:5]},  r: second[7:3]};
            default: pix = '{r: first[4:0], g: {second[2:0], first[7:5]}, b: second[7:3]};
        endcase
    end

endmodule

// File: rtl/cam_unpack.sv
module cam_unpack
    import cam_unpack_pkg::*;
#(
    parameter int YUV_GROUP = 4,
    parameter int RGB_GROUP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cam_pclk,
    input  logic              cam_hsync,
    input  logic              cam_vsync,
    input  logic [7:0]        cam_data,
    input  logic              cfg_pclk_rise,
    input  logic              cfg_hs_high,
    input  logic              cfg_vs_high,
    input  logic              cfg_in_rgb,
    input  logic [1:0]        cfg_order,
    input  logic [1:0]        cfg_out_fmt,
    input  logic              cfg_mono,
    input  logic [7:0]        cfg_mask_y,
    input  logic [7:0]        cfg_mask_u,
    input  logic [7:0]        cfg_mask_v,
    output logic              out_valid,
    output logic [15:0]       out_word
);

    localparam int PHASE_W = $clog2(YUV_GROUP);
    localparam logic [PHASE_W-1:0] YUV_LAST = PHASE_W'(YUV_GROUP - 1);
    localparam logic [PHASE_W-1:0] RGB_LAST = PHASE_W'(RGB_GROUP - 1);

    typedef struct packed {
        frame_cfg_t                          cfg;
        logic [PHASE_W-1:0]                  phase;
        logic [YUV_GROUP-2:0][BYTE_W-1:0]    hold;
        logic                                valid;
        logic [WORD_W-1:0]                   word;
        logic                                pend;
        logic [WORD_W-1:0]                   pend_word;
    } unp_t;

    unp_t st_d, st_q;

    logic              cap, line_act, frame_act, line_start, frame_start;
    logic [BYTE_W-1:0] cap_data;

    cam_sampler #(.DATA_W(BYTE_W)) u_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .pclk_in     (cam_pclk),
        .hs_in       (cam_hsync),
        .vs_in       (cam_vsync),
        .data_in     (cam_data),
        .pclk_rise   (cfg_pclk_rise),
        .hs_high     (cfg_hs_high),
        .vs_high     (cfg_vs_high),
        .cap         (cap),
        .cap_data    (cap_data),
        .line_act    (line_act),
        .frame_act   (frame_act),
        .line_start  (line_start),
        .frame_start (frame_start)
    );

    logic [3:0][BYTE_W-1:0] grp;
    yuv_pair_t              pair;
    rgb_pix_t               rgb;

    assign grp = {cap_data, st_q.hold[2], st_q.hold[1], st_q.hold[0]};

    cam_yuv_order u_yuv (
        .order (st_q.cfg.order),
        .grp   (grp),
        .pair  (pair)
    );

    cam_rgb_order u_rgb (
        .order  (st_q.cfg.order),
        .first  (st_q.hold[0]),
        .second (cap_data),
        .pix    (rgb)
    );

    logic [BYTE_W-1:0]  y0_m, y1_m, u_m, v_m;
    logic [WORD_W-1:0]  word_a, word_b, word_rgb;
    logic [PHASE_W-1:0] base;
    logic               accept, last;

    always_comb begin
        y0_m = pair.y0 & st_q.cfg.mask_y;
        y1_m = pair.y1 & st_q.cfg.mask_y;
        u_m  = st_q.cfg.mono ? '0 : (pair.u & st_q.cfg.mask_u);
        v_m  = st_q.cfg.mono ? '0 : (pair.v & st_q.cfg.mask_v);
        if (st_q.cfg.out_fmt == OUT_LUMA) begin
            word_a = {{BYTE_W{1'b0}}, y0_m};
            word_b = {{BYTE_W{1'b0}}, y1_m};
        end else begin
            word_a = {u_m, y0_m};
            word_b = {v_m, y1_m};
        end
        word_rgb = (st_q.cfg.out_fmt == OUT_RGB555)
                 ? {1'b0, rgb.r, rgb.g[5:1], rgb.b}
                 : {rgb.r, rgb.g, rgb.b};
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.pend  = 1'b0;
        if (frame_start) begin
            st_d.cfg = '{in_rgb: cfg_in_rgb, order: cfg_order, mono: cfg_mono,
                         out_fmt: out_fmt_e'(cfg_out_fmt), mask_y: cfg_mask_y,
                         mask_u: cfg_mask_u, mask_v: cfg_mask_v};
        end
        if (st_q.pend) begin
            st_d.valid = 1'b1;
            st_d.word  = st_q.pend_word;
        end
        base   = (line_start | frame_start) ? '0 : st_q.phase;
        accept = cap & line_act & ~frame_act;
        last   = st_q.cfg.in_rgb ? (base == RGB_LAST) : (base == YUV_LAST);
        st_d.phase = base;
        if (accept) begin
            if (base != YUV_LAST) st_d.hold[base] = cap_data;
            if (last) begin
                st_d.phase = '0;
                st_d.valid = 1'b1;
                if (st_q.cfg.in_rgb) begin
                    st_d.word = word_rgb;
                end else begin
                    st_d.word      = word_a;
                    st_d.pend      = 1'b1;
                    st_d.pend_word = word_b;
                end
            end else begin
                st_d.phase = base + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;

    AST_RGB_ONE_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.cfg.in_rgb) |=> !out_valid); // R6
    AST_YUV_PIXEL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !st_q.cfg.in_rgb && !$past(out_valid)) |=> out_valid); // R5
    AST_LUMA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !st_q.cfg.in_rgb && st_q.cfg.out_fmt == OUT_LUMA)
            |-> out_word[15:8] == '0); // R7
    AST_MONO_NO_CHROMA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !st_q.cfg.in_rgb && st_q.cfg.mono) |-> out_word[15:8] == '0); // R8
    AST_CFG_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(st_q.cfg)); // R10

endmodule

// File: tb/cam_unpack_test.sv
module cam_unpack_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cam_pclk = 1'b0, cam_hsync = 1'b0, cam_vsync = 1'b0;
    logic [7:0]  cam_data = '0;
    logic        cfg_pclk_rise = 1'b1, cfg_hs_high = 1'b1, cfg_vs_high = 1'b1;
    logic        cfg_in_rgb = 1'b0, cfg_mono = 1'b0;
    logic [1:0]  cfg_order = '0, cfg_out_fmt = '0;
    logic [7:0]  cfg_mask_y = 8'hFF, cfg_mask_u = 8'hFF, cfg_mask_v = 8'hFF;
    logic        out_valid;
    logic [15:0] out_word;

    int checks = 0;
    int errors = 0;
    int n_log  = 0;
    logic [15:0] log_w [256];
    logic [7:0]  bbuf [8];
    int          nb;
    logic [15:0] exp_w [4];

    always #4ns clk = ~clk;

    cam_unpack uut (
        .clk(clk), .rst_n(rst_n), .cam_pclk(cam_pclk), .cam_hsync(cam_hsync),
        .cam_vsync(cam_vsync), .cam_data(cam_data), .cfg_pclk_rise(cfg_pclk_rise),
        .cfg_hs_high(cfg_hs_high), .cfg_vs_high(cfg_vs_high), .cfg_in_rgb(cfg_in_rgb),
        .cfg_order(cfg_order), .cfg_out_fmt(cfg_out_fmt), .cfg_mono(cfg_mono),
        .cfg_mask_y(cfg_mask_y), .cfg_mask_u(cfg_mask_u), .cfg_mask_v(cfg_mask_v),
        .out_valid(out_valid), .out_word(out_word)
    );

    always @(negedge clk) begin
        if (out_valid && n_log < 256) begin
            log_w[n_log] = out_word;
            n_log = n_log + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic idle_levels();
        cam_pclk  = ~cfg_pclk_rise;
        cam_hsync = ~cfg_hs_high;
        cam_vsync = ~cfg_vs_high;
    endtask

    task automatic frame_begin();
        idle_levels();
        tick(3);
        cam_vsync = cfg_vs_high;
        tick(3);
        cam_vsync = ~cfg_vs_high;
        tick(3);
    endtask

    task automatic send_byte(input logic [7:0] b);
        cam_data = b;
        cam_pclk = ~cfg_pclk_rise;
        tick(2);
        cam_pclk = cfg_pclk_rise;
        tick(2);
    endtask

    task automatic send_line(input bit hs_on);
        cam_hsync = hs_on ? cfg_hs_high : ~cfg_hs_high;
        tick(2);
        for (int i = 0; i < nb; i++) send_byte(bbuf[i]);
        cam_pclk  = ~cfg_pclk_rise;
        tick(2);
        cam_hsync = ~cfg_hs_high;
        tick(3);
    endtask

    task automatic build_yuv(input logic [1:0] o, input logic [7:0] y0, u, y1, v);
        nb = 4;
        case (o)
            2'b00: begin bbuf[0] = y0; bbuf[1] = u;  bbuf[2] = y1; bbuf[3] = v;  end
            2'b01: begin bbuf[0] = y0; bbuf[1] = v;  bbuf[2] = y1; bbuf[3] = u;  end
            2'b10: begin bbuf[0] = u;  bbuf[1] = y0; bbuf[2] = v;  bbuf[3] = y1; end
            default: begin bbuf[0] = v; bbuf[1] = y0; bbuf[2] = u; bbuf[3] = y1; end
        endcase
    endtask

    task automatic build_rgb(input logic [1:0] o, input logic [4:0] r, input logic [5:0] g,
                             input logic [4:0] b);
        nb = 2;
        case (o)
            2'b00: begin bbuf[0] = {r, g[5:3]}; bbuf[1] = {g[2:0], b}; end
            2'b01: begin bbuf[0] = {b, g[5:3]}; bbuf[1] = {g[2:0], r}; end
            2'b10: begin bbuf[0] = {g[2:0], b}; bbuf[1] = {r, g[5:3]}; end
            default: begin bbuf[0] = {g[2:0], r}; bbuf[1] = {b, g[5:3]}; end
        endcase
    endtask

    task automatic expect_log(input string req, input int start, input int cnt);
        chk({req, " count"}, 16'(n_log - start), 16'(cnt));
        for (int i = 0; i < cnt; i++)
            if (start + i < n_log) chk(req, log_w[start + i], exp_w[i]);
    endtask

    task automatic set_cfg(input bit rgb_in, input logic [1:0] o, input logic [1:0] of,
                           input bit mono);
        cfg_in_rgb  = rgb_in;
        cfg_order   = o;
        cfg_out_fmt = of;
        cfg_mono    = mono;
        cfg_mask_y  = 8'hFF; cfg_mask_u = 8'hFF; cfg_mask_v = 8'hFF;
    endtask

    task automatic t_reset();
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 actual %b expected 0", out_valid);
        end
        rst_n = 1'b1;
        idle_levels();
        tick(2);
        for (int i = 0; i < 3; i++) send_byte(8'h55);
        chk("R1 no output before a group", 16'(n_log), 16'd0);
    endtask

    task automatic t_yuv_orders();
        for (int o = 0; o < 4; o++) begin
            int s;
            set_cfg(1'b0, 2'(o), 2'b00, 1'b0);
            frame_begin();
            s = n_log;
            build_yuv(2'(o), 8'h10 + 8'(o), 8'hA1, 8'h20 + 8'(o), 8'hB2);
            send_line(1'b1);
            exp_w[0] = {8'hA1, 8'h10 + 8'(o)};
            exp_w[1] = {8'hB2, 8'h20 + 8'(o)};
            expect_log("R5 yuv order", s, 2);
        end
    endtask

    task automatic t_rgb_orders();
        for (int o = 0; o < 4; o++) begin
            int s;
            set_cfg(1'b1, 2'(o), 2'b11, 1'b0);
            frame_begin();
            s = n_log;
            build_rgb(2'(o), 5'h13, 6'h2D, 5'h0A);
            send_line(1'b1);
            exp_w[0] = {5'h13, 6'h2D, 5'h0A};
            expect_log("R6 rgb order", s, 1);
        end
    endtask

    task automatic t_out_formats();
        int s;
        set_cfg(1'b1, 2'b10, 2'b10, 1'b0);
        frame_begin();
        s = n_log;
        build_rgb(2'b10, 5'h1F, 6'h15, 5'h01);
        send_line(1'b1);
        exp_w[0] = {1'b0, 5'h1F, 5'h0A, 5'h01};
        expect_log("R7 rgb555", s, 1);

        set_cfg(1'b1, 2'b00, 2'b01, 1'b0);
        frame_begin();
        s = n_log;
        build_rgb(2'b00, 5'h05, 6'h3C, 5'h12);
        send_line(1'b1);
        exp_w[0] = {5'h05, 6'h3C, 5'h12};
        expect_log("R7 rgb in luma code", s, 1);

        set_cfg(1'b0, 2'b00, 2'b01, 1'b0);
        frame_begin();
        s = n_log;
        build_yuv(2'b00, 8'h33, 8'h44, 8'h55, 8'h66);
        send_line(1'b1);
        exp_w[0] = 16'h0033; exp_w[1] = 16'h0055;
        expect_log("R7 luma only", s, 2);

        set_cfg(1'b0, 2'b00, 2'b11, 1'b0);
        frame_begin();
        s = n_log;
        send_line(1'b1);
        exp_w[0] = 16'h4433; exp_w[1] = 16'h6655;
        expect_log("R7 yuv to rgb passes", s, 2);
    endtask

    task automatic t_mono_mask();
        int s;
        set_cfg(1'b0, 2'b11, 2'b00, 1'b1);
        frame_begin();
        s = n_log;
        build_yuv(2'b11, 8'h81, 8'h92, 8'hA3, 8'hB4);
        send_line(1'b1);
        exp_w[0] = 16'h0081; exp_w[1] = 16'h00A3;
        expect_log("R8 mono", s, 2);

        set_cfg(1'b0, 2'b01, 2'b00, 1'b0);
        cfg_mask_y = 8'hF0; cfg_mask_u = 8'h0F; cfg_mask_v = 8'h3C;
        frame_begin();
        s = n_log;
        build_yuv(2'b01, 8'hDB, 8'h7E, 8'h5A, 8'hFF);
        send_line(1'b1);
        exp_w[0] = {8'h0E, 8'hD0}; exp_w[1] = {8'h3C, 8'h50};
        expect_log("R9 posterize", s, 2);
    endtask

    task automatic t_polarity();
        int s;
        set_cfg(1'b0, 2'b00, 2'b00, 1'b0);
        cfg_pclk_rise = 1'b0;
        frame_begin();
        s = n_log;
        build_yuv(2'b00, 8'h01, 8'h02, 8'h03, 8'h04);
        send_line(1'b1);
        exp_w[0] = 16'h0201; exp_w[1] = 16'h0403;
        expect_log("R2 falling capture", s, 2);
        cfg_pclk_rise = 1'b1;

        cfg_hs_high = 1'b0; cfg_vs_high = 1'b0;
        frame_begin();
        s = n_log;
        build_yuv(2'b00, 8'h11, 8'h22, 8'h33, 8'h44);
        send_line(1'b1);
        exp_w[0] = 16'h2211; exp_w[1] = 16'h4433;
        expect_log("R3 low active syncs", s, 2);

        s = n_log;
        send_line(1'b0);
        chk("R3 bytes outside line ignored", 16'(n_log - s), 16'd0);
        cfg_hs_high = 1'b1; cfg_vs_high = 1'b1;
    endtask

    task automatic t_restart_hold();
        int s;
        set_cfg(1'b0, 2'b00, 2'b00, 1'b0);
        frame_begin();
        s = n_log;
        nb = 3; bbuf[0] = 8'hEE; bbuf[1] = 8'hEE; bbuf[2] = 8'hEE;
        send_line(1'b1);
        build_yuv(2'b00, 8'h61, 8'h62, 8'h63, 8'h64);
        send_line(1'b1);
        exp_w[0] = 16'h6261; exp_w[1] = 16'h6463;
        expect_log("R4 line restart", s, 2);

        cfg_order = 2'b10; cfg_mask_y = 8'h0F;
        s = n_log;
        send_line(1'b1);
        expect_log("R10 mid-frame config ignored", s, 2);
        frame_begin();
        s = n_log;
        build_yuv(2'b10, 8'h61, 8'h62, 8'h63, 8'h64);
        send_line(1'b1);
        exp_w[0] = 16'h6201; exp_w[1] = 16'h6403;
        expect_log("R10 config at frame start", s, 2);
    endtask

    task automatic t_latency();
        logic [3:0] seen;
        set_cfg(1'b0, 2'b00, 2'b00, 1'b0);
        frame_begin();
        cam_hsync = 1'b1;
        tick(2);
        for (int i = 0; i < 3; i++) send_byte(8'h70 + 8'(i));
        cam_data = 8'h7F;
        cam_pclk = 1'b0;
        tick(2);
        cam_pclk = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            seen[i] = out_valid;
        end
        chk("R11 valid timing", 16'(seen), 16'b0110);
        cam_hsync = 1'b0;
        tick(3);
    endtask

    initial begin
        tick(3);
        t_reset();
        t_yuv_orders();
        t_rgb_orders();
        t_out_formats();
        t_mono_mask();
        t_polarity();
        t_restart_hold();
        t_latency();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1600us;
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule